// File: doc/BRIEF.md
# Framer error interrupt status register

This block gathers six error event lines from a line framer (transmit slip, receive slip, CRC block error, CAS multiframe signal error, multiframe alignment error and frame pattern error) into an 8-bit status register. Each line is sampled every clock and only its rising edge sets a status bit. The bit then stays at 1 until software clears it. An 8-bit enable register selects which status bits can raise the single interrupt request output.

A control input selects how a set bit is cleared. In read-clear mode, reading the status register clears it after the read. In write-one-clear mode, software clears a bit by writing a 1 to its position. Two inputs give the line type (T1 or E1) and say whether CRC framing is in use. Status bits that do not apply to the current combination read as zero and do not raise the interrupt. Any value latched in such a bit is discarded. The slip bits only say that a slip occurred. The slip type is kept elsewhere.

Software accesses the block through a synchronous port with a one-bit address, a write strobe, a read strobe, write data and combinational read data.

Top module: `err_irq_status`

## Requirements
- R1: A status bit is set one clock edge after its event input goes from 0 to 1. An input that stays high does not set the bit again once the bit has been cleared.
- R2: The status bit positions are: transmit slip at bit 7, receive slip at bit 6, CRC block error at bit 3, CAS signal error at bit 2, multiframe alignment error at bit 1, and frame pattern error at bit 0.
- R3: `irq` is 1 exactly when at least one applicable status bit is 1 and its enable bit is also 1.
- R4: With `latch_mode`=0, a read of the status register (`addr`=0, `rd_en`=1) returns the current bits and clears all of them at that clock edge.
- R5: With `latch_mode`=1, a write to the status register clears each bit whose `wdata` bit is 1 and leaves the others unchanged. Reads do not clear in this mode. With `latch_mode`=0, writes to the status register have no effect.
- R6: If an event edge arrives in the same cycle as a clear of its bit, by either read or write, the bit ends up set.
- R7: Bit 3 applies only when `crc_frm`=1, in both T1 and E1. Otherwise it reads 0.
- R8: Bits 2 and 1 apply only when `line_e1`=1 and read 0 when `line_e1`=0. Bits that do not apply never raise `irq`, and a value latched in them is lost once they stop applying.
- R9: Status and enable bits 5 and 4 always read 0. Writing 1 to them has no effect.
- R10: After reset, all status and enable bits are 0 and `irq` is 0.
- R11: A write with `addr`=1 loads the enable register, and `addr`=1 reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_slip | input | 1 | Transmit slip event |
| ev_rx_slip | input | 1 | Receive slip event |
| ev_crc | input | 1 | CRC block error event |
| ev_cas | input | 1 | CAS multiframe signal error event |
| ev_mfa | input | 1 | Multiframe alignment error event |
| ev_frm | input | 1 | Frame pattern error event |
| line_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| crc_frm | input | 1 | 1 = CRC framing (extended superframe or CRC multiframe) |
| latch_mode | input | 1 | 0 = read clears, 1 = write one to clear |
| addr | input | 1 | 0 = status register, 1 = enable register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
Each event line is first pulsed on its own, which separates the bit positions. A held-high level then tells edge capture apart from level capture. All lines are pulsed together under each line and framing combination, which exposes the applicability mask. Clears that coincide with a new edge, issued under both clear modes, tell a set-wins design from a clear-wins design. Changing the line mode while a bit is latched, then changing it back, separates a design that discards the value from one that only hides it on read.

// File: rtl/err_irq_status.sv
module err_irq_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_tx_slip,
  input  logic         ev_rx_slip,
  input  logic         ev_crc,
  input  logic         ev_cas,
  input  logic         ev_mfa,
  input  logic         ev_frm,
  input  logic         line_e1,
  input  logic         crc_frm,
  input  logic         latch_mode,
  input  logic         addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);

  localparam logic [W-1:0] RSV_KEEP = W'(8'hCF);

  logic [W-1:0] src, src_q, rise, valid, clr, st, en;

  assign src   = W'({ev_tx_slip, ev_rx_slip, 2'b00, ev_crc, ev_cas, ev_mfa, ev_frm});
  assign rise  = src & ~src_q;
  assign valid = W'({2'b11, 2'b00, crc_frm, line_e1, line_e1, 1'b1});

  always_comb begin
    clr = '0;
    if (!addr && !latch_mode && rd_en) clr = '1;
    else if (!addr && latch_mode && wr_en) clr = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      st    <= '0;
      en    <= '0;
    end else begin
      src_q <= src;
      st    <= ((st & ~clr) | rise) & valid;
      if (wr_en && addr) en <= wdata & RSV_KEEP;
    end
  end

  assign rdata = addr ? en : (st & valid);
  assign irq   = |(st & en & valid);

  // R1: rising edge sets the bit
  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_frm) |=> rdata[0] || addr);

  // R1: a held level does not set a cleared bit again
  p_level_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frm && $past(ev_frm) && !st[0]) |=> !st[0]);

  // R3: no interrupt while nothing is enabled
  p_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  // R5: write-one-clear removes the bit when no new edge arrives
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && wr_en && !addr && wdata[7] && !(ev_tx_slip && !$past(ev_tx_slip)))
      |=> !st[7]);

  // R6: edge during a read-clear keeps the bit
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && rd_en && !addr && $rose(ev_rx_slip)) |=> st[6]);

  // R8: E1-only bits never interrupt on a T1 line
  p_t1_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_e1 && (en & st & valid) == '0) |-> !irq);

endmodule

// File: tb/test_err_irq_status.sv
module test_err_irq_status;
  logic clk = 0, rst_n = 0;
  logic [5:0] ev = '0;
  logic line_e1 = 1, crc_frm = 1, latch_mode = 0;
  logic addr = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  err_irq_status i_err_irq_status (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_slip(ev[5]), .ev_rx_slip(ev[4]), .ev_crc(ev[3]),
    .ev_cas(ev[2]), .ev_mfa(ev[1]), .ev_frm(ev[0]),
    .line_e1(line_e1), .crc_frm(crc_frm), .latch_mode(latch_mode),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk); ev = ev | m;
    @(negedge clk); ev = ev & ~m;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0; wdata = '0;
  endtask

  task automatic flush();
    logic [7:0] v;
    logic lm;
    lm = latch_mode; latch_mode = 0; rd(0, v); latch_mode = lm;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1; check("R10 irq", {7'd0, irq}, 8'h00);
    rd(0, v); check("R10 status", v, 8'h00);
    rd(1, v); check("R10 enable", v, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    logic [7:0] exp [6] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h40, 8'h80};
    line_e1 = 1; crc_frm = 1; latch_mode = 0;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      rd(0, v); check("R2 bit position", v, exp[i]);
      rd(0, v); check("R4 read clears", v, 8'h00);
    end
  endtask

  task automatic t_level();
    logic [7:0] v;
    @(negedge clk); ev[0] = 1;
    repeat (4) @(negedge clk);
    rd(0, v); check("R1 edge latched", v, 8'h01);
    rd(0, v); check("R1 level no retrigger", v, 8'h00);
    @(negedge clk); ev[0] = 0;
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(1, 8'h01);
    pulse(6'h20);
    #1 check("R3 disabled bit quiet", {7'd0, irq}, 8'h00);
    wr(1, 8'h80);
    #1 check("R3 enabled bit irq", {7'd0, irq}, 8'h01);
    flush();
    #1 check("R3 irq drops on clear", {7'd0, irq}, 8'h00);
    wr(1, 8'hFF);
    rd(1, v); check("R11 R9 enable readback", v, 8'hCF);
    wr(1, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    latch_mode = 1;
    pulse(6'h10);
    rd(0, v); check("R5 read keeps", v, 8'h40);
    rd(0, v); check("R5 read keeps again", v, 8'h40);
    wr(0, 8'h80);
    rd(0, v); check("R5 other bit write", v, 8'h40);
    wr(0, 8'h40);
    rd(0, v); check("R5 write one clears", v, 8'h00);
    latch_mode = 0;
    pulse(6'h01);
    wr(0, 8'hFF);
    rd(0, v); check("R5 write ignored in read-clear", v, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    latch_mode = 1;
    pulse(6'h01);
    @(negedge clk); ev[0] = 1; addr = 0; wr_en = 1; wdata = 8'h01;
    @(negedge clk); ev[0] = 0; wr_en = 0; wdata = '0;
    rd(0, v); check("R6 edge beats write clear", v, 8'h01);
    wr(0, 8'h01);
    latch_mode = 0;
    @(negedge clk); ev[1] = 1; addr = 0; rd_en = 1; #1 v = rdata;
    check("R6 read before edge", v, 8'h00);
    @(negedge clk); ev[1] = 0; rd_en = 0;
    rd(0, v); check("R6 edge beats read clear", v, 8'h02);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    latch_mode = 0;
    line_e1 = 0; crc_frm = 0; pulse(6'h3F);
    rd(0, v); check("R7 R8 T1 plain", v, 8'hC1);
    line_e1 = 0; crc_frm = 1; pulse(6'h3F);
    rd(0, v); check("R7 T1 CRC", v, 8'hC9);
    line_e1 = 1; crc_frm = 0; pulse(6'h3F);
    rd(0, v); check("R7 E1 no CRC", v, 8'hC7);
    line_e1 = 1; crc_frm = 1; pulse(6'h3F);
    rd(0, v); check("R2 E1 CRC all", v, 8'hCF);
  endtask

  task automatic t_discard();
    logic [7:0] v;
    latch_mode = 1; line_e1 = 1; crc_frm = 1;
    pulse(6'h04);
    wr(1, 8'h04);
    #1 check("R8 E1 bit irq", {7'd0, irq}, 8'h01);
    @(negedge clk); line_e1 = 0;
    #1 check("R8 T1 irq excluded", {7'd0, irq}, 8'h00);
    rd(0, v); check("R8 T1 reads zero", v, 8'h00);
    @(negedge clk); line_e1 = 1;
    @(negedge clk);
    rd(0, v); check("R8 value discarded", v, 8'h00);
    wr(1, 8'h00);
    latch_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_level();
    t_irq();
    t_w1c();
    t_collide();
    t_modes();
    t_discard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule